// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the device-side core of a synchronous DRAM column access path. It takes READ and WRITE commands carrying a bank and a column, runs a burst of four words over an internal array of four banks by 256 columns of 16 bits, and drives read data on a data output with an output enable. Write data is captured from a separate data input. Row activation, refresh, precharge, power-down and mode programming live elsewhere. This block only sequences column bursts.

A clock-enable input is registered on every rising edge. When the registered value is low and a burst is busy, the next internal edge is suppressed. On a suppressed edge the burst position, the CAS latency countdown and the captured address do not change, no write happens, and the data on the output stays driven with the output enable still high. Commands and write data present on a suppressed edge are lost. Raising the clock enable lets the edge after the one that samples it run normally.

The controller is a five-state machine. In `ST_IDLE` it accepts READ (to `ST_RD_WAIT`) or WRITE (to `ST_WR_BEAT`, with word 0 stored on the command edge). `ST_RD_WAIT` counts CAS latency and, on its final internal edge, places word 0 on the output and moves to `ST_RD_BEAT`. `ST_RD_BEAT` presents the remaining words and moves to `ST_RD_TAIL` after the last one. `ST_RD_TAIL` releases the output and returns to `ST_IDLE`. `ST_WR_BEAT` stores the remaining words and returns to `ST_IDLE` after the last one. Each transition happens only on a non-suppressed internal edge.

Top module: `sdram_burst_core`

## Requirements
- R1: The command code is 2'b01 READ and 2'b10 WRITE. Codes 2'b00 and 2'b11 are no-operation. A command is accepted only in idle on a non-suppressed edge, and a command presented while a burst is busy has no effect on the array or on the outputs.
- R2: A WRITE stores `dq_in` of the command edge at column `col`, then the `dq_in` of each of the next three internal edges. The columns follow in sequence: the low two column bits increment modulo 4 and the upper six bits stay fixed.
- R3: After a READ accepted at internal edge E0, `dq_oe` stays low after E0 and E1. After E2, `dq_oe` is high and `dq_out` holds the word at `col`. The next three internal edges present the following words in the same wrapping order as R2. `dq_oe` falls on the internal edge after the last word.
- R4: `cke` is registered on every rising edge. A low sample suppresses the next edge whenever a burst is busy at that edge. A high sample lets the next edge run.
- R5: A suppressed edge leaves `dq_out`, `dq_oe` and the burst position unchanged.
- R6: Write data and commands present at a suppressed edge are ignored. The burst resumes with the data presented at the next internal edge.
- R7: Suppressed edges do not count toward the 2-cycle CAS latency.
- R8: An active-low synchronous reset returns the block to idle with `dq_oe` low and the registered clock enable high.
- R9: `cke` sampled low while idle has no effect: a READ that follows with `cke` high keeps the timing of R3.
- R10: The four banks are independent: the same column in different banks holds different data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable, registered on every edge |
| cmd | input | 2 | Command code: 00/11 no-op, 01 READ, 10 WRITE |
| bank | input | 2 | Bank select for the command |
| col | input | 8 | Start column for the command |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | High while read data is driven |

## Verification
Clock suspension can coincide with the CAS latency countdown and with a write capture edge. The bench provokes the first by issuing a READ with `cke` low on the command edge. It expects word 0 one cycle later than R3, with the output enable still low after the second edge. It provokes the second by dropping `cke` during a write burst while driving junk data and a stray command on the frozen edges. It then reads the burst back and checks that only the data from internal edges landed, in wrap order.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_WAIT = 3'd1,
        ST_RD_BEAT = 3'd2,
        ST_RD_TAIL = 3'd3,
        ST_WR_BEAT = 3'd4
    } state_e;

endpackage

// File: rtl/sbc_cke_gate.sv
// Registers the clock enable and produces the internal edge qualifier.
module sbc_cke_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic busy,
    output logic tick
);
    logic cke_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke;
        end
    end

    // Freeze only a busy burst; idle low samples are harmless.
    assign tick = !busy || cke_q;
endmodule

// File: rtl/sbc_col_seq.sv
// Sequential column within an aligned burst-length group.
module sbc_col_seq #(
    parameter int COL_W  = 8,
    parameter int BEAT_W = 2
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0]  seq_col
);
    logic [BEAT_W-1:0] low_sum;

    assign low_sum = base_col[BEAT_W-1:0] + beat;
    assign seq_col = {base_col[COL_W-1:BEAT_W], low_sum};
endmodule

// File: rtl/sbc_mem_array.sv
// Banked storage, one synchronous write port and one combinational read port.
module sbc_mem_array #(
    parameter int BANKS = 4,
    parameter int COLS  = 256,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(BANKS)-1:0] wbank,
    input  logic [$clog2(COLS)-1:0]  wcol,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(BANKS)-1:0] rbank,
    input  logic [$clog2(COLS)-1:0]  rcol,
    output logic [DW-1:0]            rdata
);
    localparam int DEPTH = BANKS * COLS;
    localparam int AW    = $clog2(BANKS) + $clog2(COLS);

    logic [DW-1:0] store_q [0:DEPTH-1];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    assign waddr = {wbank, wcol};
    assign raddr = {rbank, rcol};

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core
    import sdram_burst_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int COLS      = 256,
    parameter int DW        = 16,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke,
    input  logic [1:0]               cmd,
    input  logic [$clog2(BANKS)-1:0] bank,
    input  logic [$clog2(COLS)-1:0]  col,
    input  logic [DW-1:0]            dq_in,
    output logic [DW-1:0]            dq_out,
    output logic                     dq_oe
);
    localparam int BA_W   = $clog2(BANKS);
    localparam int COL_W  = $clog2(COLS);
    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam int LAT_W  = $clog2(CAS_LAT + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
    localparam logic [LAT_W-1:0]  LAT_LAST  = LAT_W'(CAS_LAT - 1);

    state_e state_q, state_d;
    cmd_e   cmd_in;

    logic [BA_W-1:0]   bank_q;
    logic [COL_W-1:0]  col_q;
    logic [BEAT_W-1:0] beat_q;
    logic [LAT_W-1:0]  lat_q;
    logic [DW-1:0]     dq_q;
    logic              oe_q;

    logic              tick;
    logic              busy;
    logic              accept_rd;
    logic              accept_wr;
    logic              last_beat;
    logic              lat_done;
    logic [COL_W-1:0]  seq_col;
    logic [DW-1:0]     rd_data;
    logic              mem_we;
    logic [BA_W-1:0]   wr_bank;
    logic [COL_W-1:0]  wr_col;

    assign cmd_in    = cmd_e'(cmd);
    assign busy      = (state_q != ST_IDLE);
    assign accept_rd = tick && (state_q == ST_IDLE) && (cmd_in == CMD_READ);
    assign accept_wr = tick && (state_q == ST_IDLE) && (cmd_in == CMD_WRITE);
    assign last_beat = (beat_q == LAST_BEAT);
    assign lat_done  = (lat_q == LAT_LAST);

    sbc_cke_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .busy  (busy),
        .tick  (tick)
    );

    sbc_col_seq #(
        .COL_W  (COL_W),
        .BEAT_W (BEAT_W)
    ) u_seq (
        .base_col (col_q),
        .beat     (beat_q),
        .seq_col  (seq_col)
    );

    // Write port: command edge uses the live address, later beats the latched one.
    assign mem_we  = accept_wr || (tick && (state_q == ST_WR_BEAT));
    assign wr_bank = (state_q == ST_IDLE) ? bank : bank_q;
    assign wr_col  = (state_q == ST_IDLE) ? col  : seq_col;

    sbc_mem_array #(
        .BANKS (BANKS),
        .COLS  (COLS),
        .DW    (DW)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wbank (wr_bank),
        .wcol  (wr_col),
        .wdata (dq_in),
        .rbank (bank_q),
        .rcol  (seq_col),
        .rdata (rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: every move needs a non-suppressed edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_rd) begin
                    state_d = ST_RD_WAIT;
                end else if (accept_wr) begin
                    state_d = ST_WR_BEAT;
                end
            end
            ST_RD_WAIT: begin
                if (tick && lat_done) begin
                    state_d = ST_RD_BEAT;
                end
            end
            ST_RD_BEAT: begin
                if (tick && last_beat) begin
                    state_d = ST_RD_TAIL;
                end
            end
            ST_RD_TAIL: begin
                if (tick) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_BEAT: begin
                if (tick && last_beat) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers, all held on a suppressed edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            beat_q <= '0;
            lat_q  <= '0;
            dq_q   <= '0;
            oe_q   <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_rd || accept_wr) begin
                        bank_q <= bank;
                        col_q  <= col;
                        lat_q  <= '0;
                        beat_q <= accept_wr ? BEAT_W'(1) : '0;
                    end
                end
                ST_RD_WAIT: begin
                    if (lat_done) begin
                        dq_q   <= rd_data;
                        oe_q   <= 1'b1;
                        beat_q <= beat_q + BEAT_W'(1);
                    end else begin
                        lat_q  <= lat_q + LAT_W'(1);
                    end
                end
                ST_RD_BEAT: begin
                    dq_q   <= rd_data;
                    beat_q <= beat_q + BEAT_W'(1);
                end
                ST_RD_TAIL: begin
                    oe_q   <= 1'b0;
                end
                ST_WR_BEAT: begin
                    beat_q <= beat_q + BEAT_W'(1);
                end
                default: begin
                    oe_q   <= 1'b0;
                end
            endcase
        end
    end

    assign dq_out = dq_q;
    assign dq_oe  = oe_q;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int DW     = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              tick,
    input logic              busy,
    input logic              mem_we,
    input logic [BEAT_W-1:0] beat,
    input logic [DW-1:0]     dq_out,
    input logic              dq_oe
);
    AST_FROZEN_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(dq_out) && $stable(dq_oe))); // R5

    AST_FROZEN_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(beat)); // R5

    AST_CKE_HIGH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> tick); // R4

    AST_IDLE_NEVER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tick); // R9

    AST_IDLE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dq_oe); // R8

    AST_NO_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> tick); // R6
endmodule

bind sdram_burst_core sbc_checker #(
    .DW     (DW),
    .BEAT_W (BEAT_W)
) u_sbc_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .tick   (tick),
    .busy   (busy),
    .mem_we (mem_we),
    .beat   (beat_q),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/sdram_burst_core_bench.sv
module sdram_burst_core_bench;
    localparam logic [1:0] C_NOP = 2'b00;
    localparam logic [1:0] C_RD  = 2'b01;
    localparam logic [1:0] C_WR  = 2'b10;
    localparam logic [1:0] C_RSV = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [1:0]  bank = '0;
    logic [7:0]  col = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] mdl [0:3][0:255];

    always #5 clk = ~clk;

    sdram_burst_core u_sdram_burst_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .cmd    (cmd),
        .bank   (bank),
        .col    (col),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    function automatic logic [7:0] wcol(input logic [7:0] base, input int i);
        logic [1:0] lo;
        lo = base[1:0] + 2'(i);
        return {base[7:2], lo};
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act={oe,dq}=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive inputs, pass one rising edge, return at the falling edge
    task automatic cyc(input logic [1:0] c, input logic [1:0] b, input logic [7:0] cl,
                       input logic [15:0] d, input logic k);
        cmd = c; bank = b; col = cl; dq_in = d; cke = k;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] b, input logic [7:0] cl, input logic [15:0] seed);
        for (int i = 0; i < 4; i++) begin
            cyc(i == 0 ? C_WR : C_NOP, b, cl, seed + 16'(i), 1'b1);
            mdl[b][wcol(cl, i)] = seed + 16'(i);
        end
        cyc(C_NOP, 0, 0, 0, 1'b1);
    endtask

    task automatic do_read(input logic [1:0] b, input logic [7:0] cl, input string req);
        cyc(C_RD, b, cl, 0, 1'b1);
        chk({req, " oe low after E0"}, {dq_oe, 16'h0}, 17'h0);
        cyc(C_NOP, 0, 0, 0, 1'b1);
        chk({req, " oe low after E1"}, {dq_oe, 16'h0}, 17'h0);
        for (int i = 0; i < 4; i++) begin
            cyc(C_NOP, 0, 0, 0, 1'b1);
            chk({req, " word"}, {dq_oe, dq_out}, {1'b1, mdl[b][wcol(cl, i)]});
        end
        cyc(C_NOP, 0, 0, 0, 1'b1);
        chk({req, " oe released"}, {dq_oe, 16'h0}, 17'h0);
    endtask

    task automatic t_reset;
        chk("R8 reset oe", {dq_oe, 16'h0}, 17'h0);
    endtask

    task automatic t_basic;
        do_write(2'd0, 8'h10, 16'hA000);
        do_read(2'd0, 8'h10, "R3 R2 basic");
    endtask

    task automatic t_wrap;
        do_write(2'd3, 8'h0E, 16'hB100);
        do_read(2'd3, 8'h0D, "R2 wrap");
    endtask

    task automatic t_banks;
        do_write(2'd1, 8'h40, 16'h1110);
        do_write(2'd2, 8'h40, 16'h2220);
        do_read(2'd1, 8'h40, "R10 bank1");
        do_read(2'd2, 8'h40, "R10 bank2");
    endtask

    task automatic t_read_suspend;
        cyc(C_RD, 2'd0, 8'h10, 0, 1'b1);  // E0
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E1
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E2
        chk("R4 word0", {dq_oe, dq_out}, {1'b1, mdl[0][8'h10]});
        cyc(C_NOP, 0, 0, 0, 1'b0);         // E3 runs, samples low
        chk("R4 word1 on low sample edge", {dq_oe, dq_out}, {1'b1, mdl[0][8'h11]});
        cyc(C_RD, 2'd2, 8'h40, 0, 1'b1);   // E4 suppressed
        chk("R5 held while frozen", {dq_oe, dq_out}, {1'b1, mdl[0][8'h11]});
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E5
        chk("R4 resume word2", {dq_oe, dq_out}, {1'b1, mdl[0][8'h12]});
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E6
        chk("R5 word3", {dq_oe, dq_out}, {1'b1, mdl[0][8'h13]});
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E7
        chk("R3 oe released after suspend", {dq_oe, 16'h0}, 17'h0);
    endtask

    task automatic t_latency_suspend;
        cyc(C_RD, 2'd3, 8'h0C, 0, 1'b0);   // E0 accepted, low sampled
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E1 suppressed
        chk("R7 oe low after frozen E1", {dq_oe, 16'h0}, 17'h0);
        cyc(C_NOP, 0, 0, 0, 1'b1);         // E2 latency step
        chk("R7 latency not counted", {dq_oe, 16'h0}, 17'h0);
        for (int i = 0; i < 4; i++) begin
            cyc(C_NOP, 0, 0, 0, 1'b1);
            chk("R7 delayed word", {dq_oe, dq_out}, {1'b1, mdl[3][wcol(8'h0C, i)]});
        end
        cyc(C_NOP, 0, 0, 0, 1'b1);
        chk("R7 oe released", {dq_oe, 16'h0}, 17'h0);
    endtask

    task automatic t_write_suspend;
        cyc(C_WR, 2'd1, 8'h81, 16'hC000, 1'b1);  // E0 word0
        cyc(C_NOP, 0, 0, 16'hC001, 1'b0);        // E1 word1, low sampled
        cyc(C_RD, 2'd1, 8'h81, 16'hDEAD, 1'b0);  // E2 suppressed
        chk("R6 oe low during write suspend", {dq_oe, 16'h0}, 17'h0);
        cyc(C_WR, 2'd0, 8'h10, 16'hBEEF, 1'b1);  // E3 suppressed
        cyc(C_NOP, 0, 0, 16'hC002, 1'b1);        // E4 word2
        cyc(C_NOP, 0, 0, 16'hC003, 1'b1);        // E5 word3
        for (int i = 0; i < 4; i++) mdl[1][wcol(8'h81, i)] = 16'hC000 + 16'(i);
        cyc(C_NOP, 0, 0, 0, 1'b1);
        do_read(2'd1, 8'h81, "R6 frozen data ignored");
        do_read(2'd0, 8'h10, "R6 frozen command ignored");
    endtask

    task automatic t_ignore_cmd;
        do_write(2'd0, 8'h20, 16'h5A50);
        cyc(C_RD, 2'd0, 8'h10, 0, 1'b1);          // E0
        cyc(C_NOP, 0, 0, 0, 1'b1);                // E1
        cyc(C_WR, 2'd0, 8'h20, 16'hFFFF, 1'b1);   // E2 write during burst
        chk("R1 word0 during stray write", {dq_oe, dq_out}, {1'b1, mdl[0][8'h10]});
        cyc(C_RD, 2'd1, 8'h40, 16'hFFFF, 1'b1);   // E3 read during burst
        chk("R1 word1 during stray read", {dq_oe, dq_out}, {1'b1, mdl[0][8'h11]});
        cyc(C_NOP, 0, 0, 0, 1'b1);
        cyc(C_NOP, 0, 0, 0, 1'b1);
        cyc(C_NOP, 0, 0, 0, 1'b1);
        chk("R1 burst ends normally", {dq_oe, 16'h0}, 17'h0);
        for (int i = 0; i < 3; i++) begin
            cyc(C_RSV, 2'd0, 8'h20, 16'hFFFF, 1'b1);
            chk("R1 reserved code is no-op", {dq_oe, 16'h0}, 17'h0);
        end
        do_read(2'd0, 8'h20, "R1 stray commands left array intact");
    endtask

    task automatic t_idle_cke;
        for (int i = 0; i < 3; i++) begin
            cyc(C_NOP, 0, 0, 0, 1'b0);
            chk("R9 idle low cke", {dq_oe, 16'h0}, 17'h0);
        end
        do_read(2'd2, 8'h40, "R9 read after idle low cke");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R4 act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_banks();
        t_read_suspend();
        t_latency_suspend();
        t_write_suspend();
        t_ignore_cmd();
        t_idle_cke();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule